// File: doc/BRIEF.md
# Configurable Operand Input Pipeline

This block is the input stage for one operand of a multiply/add slice. The operand comes either from a parallel input port or from the cascade input driven by the previous slice. A build-time source parameter picks which one. The chosen value passes through zero, one or two register stages. Three consumers tap the chain separately:

- the ALU path;
- the multiplier path;
- a cascade output that feeds the next slice.

Each stage has its own clock enable. Reset works in one of two ways, chosen at build time. In synchronous mode each stage has its own reset input. In asynchronous mode one shared reset clears both stages. Parameter bits can invert the clock, the reset inputs and the multiplier tap-select bit inside the block. The cascade depth must suit the main depth. An illegal pairing is reported when the design is elaborated. The multiplier and the ALU are not part of this block.

Top module: `operand_input_pipe`

## Requirements
- R1: With `DEPTH` = 0, `alu_o`, `mult_o` and `casc_o` all equal the selected source in the same cycle, with no register delay.
- R2: With `FROM_CASCADE` = 0 the source is `par_i`; with `FROM_CASCADE` = 1 the source is `casc_i`.
- R3: With `DEPTH` = 1 there are two stages, both loaded directly from the source. The first stage loads when `ce1_i` is high and the second when `ce2_i` is high. `alu_o` and `casc_o` present the second stage.
- R4: With `DEPTH` = 1 or 2, `mult_o` presents the first stage when the effective tap-select bit is 1, and the second stage when it is 0.
- R5: With `DEPTH` = 2 the stages form a chain. The first stage loads the source on `ce1_i`. The second stage loads the first stage on `ce2_i`. `alu_o` presents the second stage.
- R6: `casc_o` presents the second stage when `CASC_DEPTH` equals `DEPTH`, and the first stage when `DEPTH` = 2 and `CASC_DEPTH` = 1. Legal pairs are (0,0), (1,1), (2,1) and (2,2); any other pair is flagged at elaboration.
- R7: With `ASYNC_RST` = 0, a high effective `srst1_i` (or `srst2_i`) clears stage 1 (or stage 2) to zero at the next active clock edge, whatever its clock enable. `arst_i` has no effect in this mode.
- R8: With `ASYNC_RST` = 1, a high effective `arst_i` clears both stages to zero at once and keeps them at zero. `srst1_i` and `srst2_i` have no effect in this mode.
- R9: `INV_CLK` = 1 makes the stages load on the falling clock edge. `INV_RST` = 1 makes all reset inputs active low. `INV_MODE` = 1 inverts `mode_i` before it selects the multiplier tap.
- R10: A stage whose enable is low and which is not in reset keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the active edge depends on `INV_CLK` |
| arst_i | input | 1 | Shared asynchronous reset, used when `ASYNC_RST` = 1 |
| srst1_i | input | 1 | Synchronous reset of stage 1, used when `ASYNC_RST` = 0 |
| srst2_i | input | 1 | Synchronous reset of stage 2, used when `ASYNC_RST` = 0 |
| ce1_i | input | 1 | Clock enable of stage 1 |
| ce2_i | input | 1 | Clock enable of stage 2 |
| mode_i | input | 1 | Multiplier tap select: 1 selects stage 1, 0 selects stage 2 (after optional inversion) |
| par_i | input | WIDTH | Parallel operand input |
| casc_i | input | WIDTH | Cascade operand input from the previous slice |
| alu_o | output | WIDTH | Operand for the ALU path |
| mult_o | output | WIDTH | Operand for the multiplier path |
| casc_o | output | WIDTH | Cascade operand for the next slice |

## Verification
Two events can fall on the same stage edge: a reset and a load enabled by the stage's clock enable. Random stimulus drives both resets and both enables independently, and several times per run they are high together. In those cycles the bench model expects zero in the stage, so a load that beats the reset shows up as a data mismatch on the tap that presents that stage. The same random cycles also change the tap-select bit while a stage is loading. Every output of five differently configured instances is compared with the bench model on every clock.

// File: rtl/operand_pipe_pkg.sv
package operand_pipe_pkg;

    localparam int MAX_DEPTH = 2;

    // Legal (main depth, cascade depth) pairings.
    function automatic bit depth_pair_ok(input int depth, input int casc);
        if (depth < 0 || depth > MAX_DEPTH) return 1'b0;
        if (depth == 0) return (casc == 0);
        if (depth == 1) return (casc == 1);
        return (casc == 1 || casc == 2);
    endfunction

endpackage

// File: rtl/opnd_src_sel.sv
module opnd_src_sel #(
    parameter int WIDTH        = 27,
    parameter bit FROM_CASCADE = 1'b0
) (
    input  logic [WIDTH-1:0] par_i,
    input  logic [WIDTH-1:0] casc_i,
    output logic [WIDTH-1:0] src_o
);

    generate
        if (FROM_CASCADE) begin : g_casc
            assign src_o = casc_i;
        end else begin : g_par
            assign src_o = par_i;
        end
    endgenerate

endmodule

// File: rtl/opnd_stage_reg.sv
module opnd_stage_reg #(
    parameter int WIDTH     = 27,
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic             srst_i,
    input  logic             ce_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             primed;
    } stage_t;

    stage_t cur_q;
    stage_t nxt_d;
    logic   sync_clr;

    assign sync_clr = !ASYNC_RST && srst_i;

    always_comb begin
        nxt_d = cur_q;
        if (sync_clr) begin
            nxt_d.data   = '0;
            nxt_d.primed = 1'b1;
        end else if (ce_i) begin
            nxt_d.data = d_i;
        end
    end

    generate
        if (ASYNC_RST) begin : g_async
            always_ff @(posedge clk_i or posedge arst_i) begin
                if (arst_i) begin
                    cur_q <= '{data: '0, primed: 1'b1};
                end else begin
                    cur_q <= nxt_d;
                end
            end
        end else begin : g_sync
            always_ff @(posedge clk_i) begin
                cur_q <= nxt_d;
            end

            AST_SRST_CLEARS: assert property (@(posedge clk_i)
                srst_i |=> (q_o == '0)) else $error("stage not cleared"); // R7
        end
    endgenerate

    assign q_o = cur_q.data;

    AST_CE_LOADS: assert property (@(posedge clk_i) disable iff (arst_i)
        (cur_q.primed && ce_i && !sync_clr) |=> (q_o == $past(d_i)))
        else $error("stage did not load"); // R5

    AST_HOLD_VALUE: assert property (@(posedge clk_i) disable iff (arst_i)
        (cur_q.primed && !ce_i && !sync_clr) |=> $stable(q_o))
        else $error("stage changed while disabled"); // R10

endmodule

// File: rtl/opnd_tap_sel.sv
module opnd_tap_sel #(
    parameter int WIDTH      = 27,
    parameter int DEPTH      = 1,
    parameter int CASC_DEPTH = 1
) (
    input  logic [WIDTH-1:0] src_i,
    input  logic [WIDTH-1:0] st1_i,
    input  logic [WIDTH-1:0] st2_i,
    input  logic             early_i,
    output logic [WIDTH-1:0] alu_o,
    output logic [WIDTH-1:0] mult_o,
    output logic [WIDTH-1:0] casc_o
);

    generate
        if (DEPTH == 0) begin : g_bypass
            assign alu_o  = src_i;
            assign mult_o = src_i;
            assign casc_o = src_i;
        end else begin : g_reg
            assign alu_o  = st2_i;
            assign mult_o = early_i ? st1_i : st2_i;
            if (DEPTH == 2 && CASC_DEPTH == 1) begin : g_casc_early
                assign casc_o = st1_i;
            end else begin : g_casc_late
                assign casc_o = st2_i;
            end
        end
    endgenerate

endmodule

// File: rtl/operand_input_pipe.sv
module operand_input_pipe #(
    parameter int WIDTH        = 27,
    parameter int DEPTH        = 1,
    parameter int CASC_DEPTH   = 1,
    parameter bit FROM_CASCADE = 1'b0,
    parameter bit ASYNC_RST    = 1'b0,
    parameter bit INV_CLK      = 1'b0,
    parameter bit INV_RST      = 1'b0,
    parameter bit INV_MODE     = 1'b0
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic             srst1_i,
    input  logic             srst2_i,
    input  logic             ce1_i,
    input  logic             ce2_i,
    input  logic             mode_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic [WIDTH-1:0] casc_i,
    output logic [WIDTH-1:0] alu_o,
    output logic [WIDTH-1:0] mult_o,
    output logic [WIDTH-1:0] casc_o
);

    localparam bit PAIR_OK = operand_pipe_pkg::depth_pair_ok(DEPTH, CASC_DEPTH);

    initial begin
        AST_DEPTH_PAIR: assert (PAIR_OK)
            else $error("illegal depth %0d / cascade depth %0d", DEPTH, CASC_DEPTH); // R6
    end

    logic             clk_int;
    logic             arst_eff;
    logic             srst1_eff;
    logic             srst2_eff;
    logic             early_sel;
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] st1;
    logic [WIDTH-1:0] st2;

    assign clk_int   = clk_i ^ INV_CLK;
    assign arst_eff  = ASYNC_RST ? (arst_i ^ INV_RST) : 1'b0;
    assign srst1_eff = ASYNC_RST ? 1'b0 : (srst1_i ^ INV_RST);
    assign srst2_eff = ASYNC_RST ? 1'b0 : (srst2_i ^ INV_RST);
    assign early_sel = mode_i ^ INV_MODE;

    opnd_src_sel #(
        .WIDTH       (WIDTH),
        .FROM_CASCADE(FROM_CASCADE)
    ) u_src (
        .par_i (par_i),
        .casc_i(casc_i),
        .src_o (src)
    );

    generate
        if (DEPTH == 0) begin : g_no_stage
            assign st1 = '0;
            assign st2 = '0;
        end else begin : g_stages
            logic [WIDTH-1:0] st2_in;

            if (DEPTH == 2) begin : g_chain
                assign st2_in = st1;
            end else begin : g_parallel
                assign st2_in = src;
            end

            opnd_stage_reg #(
                .WIDTH    (WIDTH),
                .ASYNC_RST(ASYNC_RST)
            ) u_stage1 (
                .clk_i (clk_int),
                .arst_i(arst_eff),
                .srst_i(srst1_eff),
                .ce_i  (ce1_i),
                .d_i   (src),
                .q_o   (st1)
            );

            opnd_stage_reg #(
                .WIDTH    (WIDTH),
                .ASYNC_RST(ASYNC_RST)
            ) u_stage2 (
                .clk_i (clk_int),
                .arst_i(arst_eff),
                .srst_i(srst2_eff),
                .ce_i  (ce2_i),
                .d_i   (st2_in),
                .q_o   (st2)
            );
        end
    endgenerate

    opnd_tap_sel #(
        .WIDTH     (WIDTH),
        .DEPTH     (DEPTH),
        .CASC_DEPTH(CASC_DEPTH)
    ) u_taps (
        .src_i  (src),
        .st1_i  (st1),
        .st2_i  (st2),
        .early_i(early_sel),
        .alu_o  (alu_o),
        .mult_o (mult_o),
        .casc_o (casc_o)
    );

endmodule

// File: tb/operand_input_pipe_bench.sv
module operand_input_pipe_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 27;
    localparam int CYCLES     = 4000;

    logic         clk = 1'b0;
    logic [W-1:0] par, casc;
    logic         ce1, ce2, mode, srst1, srst2, arst;
    int           n_checks = 0;
    int           n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0] a_alu, a_mult, a_casc;
    logic [W-1:0] b_alu, b_mult, b_casc;
    logic [W-1:0] c_alu, c_mult, c_casc;
    logic [W-1:0] d_alu, d_mult, d_casc;
    logic [W-1:0] e_alu, e_mult, e_casc;

    // A: defaults (depth 1, parallel source, sync reset)
    operand_input_pipe u_operand_input_pipe (
        .clk_i(clk), .arst_i(arst), .srst1_i(srst1), .srst2_i(srst2),
        .ce1_i(ce1), .ce2_i(ce2), .mode_i(mode), .par_i(par), .casc_i(casc),
        .alu_o(a_alu), .mult_o(a_mult), .casc_o(a_casc));

    // B: depth 2 chain, cascade 2, cascade source, inverted mode bit
    operand_input_pipe #(.DEPTH(2), .CASC_DEPTH(2), .FROM_CASCADE(1'b1), .INV_MODE(1'b1)) u_deep (
        .clk_i(clk), .arst_i(arst), .srst1_i(srst1), .srst2_i(srst2),
        .ce1_i(ce1), .ce2_i(ce2), .mode_i(mode), .par_i(par), .casc_i(casc),
        .alu_o(b_alu), .mult_o(b_mult), .casc_o(b_casc));

    // C: depth 2, cascade 1, async reset, active-low resets
    operand_input_pipe #(.DEPTH(2), .CASC_DEPTH(1), .ASYNC_RST(1'b1), .INV_RST(1'b1)) u_async (
        .clk_i(clk), .arst_i(~arst), .srst1_i(~srst1), .srst2_i(~srst2),
        .ce1_i(ce1), .ce2_i(ce2), .mode_i(mode), .par_i(par), .casc_i(casc),
        .alu_o(c_alu), .mult_o(c_mult), .casc_o(c_casc));

    // D: depth 1, falling-edge clock
    operand_input_pipe #(.INV_CLK(1'b1)) u_negclk (
        .clk_i(clk), .arst_i(arst), .srst1_i(srst1), .srst2_i(srst2),
        .ce1_i(ce1), .ce2_i(ce2), .mode_i(mode), .par_i(par), .casc_i(casc),
        .alu_o(d_alu), .mult_o(d_mult), .casc_o(d_casc));

    // E: no registers, cascade source
    operand_input_pipe #(.DEPTH(0), .CASC_DEPTH(0), .FROM_CASCADE(1'b1)) u_bypass (
        .clk_i(clk), .arst_i(arst), .srst1_i(srst1), .srst2_i(srst2),
        .ce1_i(ce1), .ce2_i(ce2), .mode_i(mode), .par_i(par), .casc_i(casc),
        .alu_o(e_alu), .mult_o(e_mult), .casc_o(e_casc));

    // Behavioural reference state
    logic [W-1:0] ma1, ma2, mb1, mb2, mc1, mc2, md1, md2;

    always @(posedge clk) begin
        ma1 <= srst1 ? '0 : (ce1 ? par : ma1);
        ma2 <= srst2 ? '0 : (ce2 ? par : ma2);
        mb1 <= srst1 ? '0 : (ce1 ? casc : mb1);
        mb2 <= srst2 ? '0 : (ce2 ? mb1 : mb2);
    end

    always @(posedge clk or posedge arst) begin
        if (arst) begin
            mc1 <= '0;
            mc2 <= '0;
        end else begin
            if (ce1) mc1 <= par;
            if (ce2) mc2 <= mc1;
        end
    end

    always @(negedge clk) begin
        md1 <= srst1 ? '0 : (ce1 ? par : md1);
        md2 <= srst2 ? '0 : (ce2 ? par : md2);
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3 R10 A alu", a_alu, ma2);
        chk("R4 A mult", a_mult, mode ? ma1 : ma2);
        chk("R6 R7 A casc", a_casc, ma2);
        chk("R5 R2 B alu", b_alu, mb2);
        chk("R9 B mult (inverted select)", b_mult, mode ? mb2 : mb1);
        chk("R6 B casc", b_casc, mb2);
        chk("R8 C alu", c_alu, mc2);
        chk("R4 R9 C mult", c_mult, mode ? mc1 : mc2);
        chk("R6 C casc (early tap)", c_casc, mc1);
        chk("R9 D alu (falling edge)", d_alu, md2);
        chk("R4 D mult", d_mult, mode ? md1 : md2);
        chk("R9 D casc", d_casc, md2);
        chk("R1 R2 E alu", e_alu, casc);
        chk("R1 E mult", e_mult, casc);
        chk("R1 E casc", e_casc, casc);
    endtask

    bit finished = 1'b0;

    initial begin
        par = '0; casc = '0; ce1 = 1'b1; ce2 = 1'b1; mode = 1'b0;
        srst1 = 1'b1; srst2 = 1'b1; arst = 1'b1;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD*8/10);
        // R7 R8: reset state of all registered instances
        chk("R7 A reset", a_alu, '0);
        chk("R7 B reset", b_mult, '0);
        chk("R8 C reset", c_casc, '0);
        chk("R7 D reset", d_alu, '0);
        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            @(posedge clk);
            #2;
            par   = W'($urandom);
            casc  = W'($urandom);
            ce1   = ($urandom % 4) != 0;
            ce2   = ($urandom % 4) != 0;
            mode  = $urandom % 2;
            srst1 = ($urandom % 8) == 0;
            srst2 = ($urandom % 8) == 0;
            arst  = ($urandom % 16) == 0;
            #(CLK_PERIOD - 4);
            compare_all();
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule